// File: doc/BRIEF.md
# Merging Write Buffer for a Word-Coded SRAM

This block sits between a simple bus slave port and an SRAM array whose error-correcting check bits cover one whole data word. The word is W bits wide, either 32 or 64. A write that fills a complete, aligned word is encoded at once and stored in the array. A write that covers only part of a word cannot be encoded by itself. Such a write is merged into a single one-word holding register. That register reaches the array only when a later access pushes it out.

Reads always see the merged contents, whether the word is in the holding register or in the array. Data fetched from the array is checked with a single-error-correct, double-error-detect code. When a request needs the array port for more than one step (an eviction, a fetch, or a read from the array), the bus is stalled with a ready signal. Software that needs a partial write to survive a reset must flush it. It can do this with a partial write to some other word, or by reading the pending word and writing it back as an aligned full word.

Top module: `ecc_merge_buf`

## Requirements
- R1: A write with all byte strobes set and the low address bits (byte offset within the word) zero is accepted with `bus_ready` high in the cycle it is presented. In that same cycle it drives one array write of that word. The stored data field sits in array bits [W-1:0], and the check bits sit above it.
- R2: A write with any strobe clear, or with a nonzero byte offset, never writes its own word to the array. The array contents of that word stay unchanged until the word is evicted.
- R3: A partial write to the word already held merges its strobed byte lanes (lane b is bits 8b+7..8b) into the held word. It is accepted in one cycle and makes no array access.
- R4: A partial write to a different word while a word is held first writes the held word to the array. It then reads the new word and merges into it, and is accepted in the third cycle.
- R5: A read of the held word returns the merged data in the same cycle and makes no array access.
- R6: A read of any other word reads the array and is accepted in the second cycle. A partial write to an unheld word while nothing is held is also accepted in the second cycle.
- R7: A single flipped bit in a fetched word, in the data or in a check bit, is corrected on both the read path and the merge path. In this case `bus_rerr` stays low.
- R8: Two flipped bits in a fetched word raise `bus_rerr` together with `bus_ready`.
- R9: An aligned full write to the held word writes through to the array and empties the holding register. A following partial write to another word then makes no eviction write. A read of the held word followed by an aligned write-back of the same value commits it.
- R10: Reset empties the holding register, so an uncommitted partial write is lost. After reset, a read of that word returns the array contents. With no request pending, `bus_ready` is high and the array port is idle.
- R11: Byte lanes are chosen only by the strobes. A write with all strobes set but a nonzero byte offset is handled as a partial write.
- R12: The array port never reads and writes in the same cycle. The master holds its request stable while `bus_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | AW+log2(W/8) | Byte address |
| bus_wdata | input | W | Write data |
| bus_strb | input | W/8 | Byte lane strobes |
| bus_we | input | 1 | Write request |
| bus_re | input | 1 | Read request |
| bus_ready | output | 1 | Request accepted this cycle |
| bus_rdata | output | W | Read data, valid with ready on a read |
| bus_rerr | output | 1 | Uncorrectable error on the fetched word |
| mem_addr | output | AW | Array word address |
| mem_we | output | 1 | Array write |
| mem_re | output | 1 | Array read, data one cycle later |
| mem_wdata | output | W+C | Data and check bits to the array |
| mem_rdata | input | W+C | Data and check bits from the array |

## Verification
The assertions assume a master that never raises read and write together. They also assume it holds address, data and strobes stable until ready, and an array that returns read data exactly one cycle after `mem_re`. The bench drives each transfer from a task that sets the request at a falling edge. That task keeps the request unchanged until ready is seen, and only then clears it. The bench's array model has a fixed one-cycle read. Error injection flips bits on that model's read path between transfers, never in the middle of one.

// File: rtl/ecc_merge_buf.sv
module ecc_merge_buf #(
  parameter int W  = 32,
  parameter int AW = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [AW+$clog2(W/8)-1:0] bus_addr,
  input  logic [W-1:0]              bus_wdata,
  input  logic [W/8-1:0]            bus_strb,
  input  logic                      bus_we,
  input  logic                      bus_re,
  output logic                      bus_ready,
  output logic [W-1:0]              bus_rdata,
  output logic                      bus_rerr,
  output logic [AW-1:0]             mem_addr,
  output logic                      mem_we,
  output logic                      mem_re,
  output logic [W+((W>32)?8:7)-1:0] mem_wdata,
  input  logic [W+((W>32)?8:7)-1:0] mem_rdata
);
  localparam int NB = W / 8;
  localparam int OB = $clog2(NB);
  localparam int C  = (W > 32) ? 8 : 7;
  localparam int R  = C - 1;

  typedef enum logic [1:0] {IDLE, FETCH, MERGE, RDATA} st_t;

  function automatic logic [R-1:0] ham(input logic [W-1:0] d);
    logic [R-1:0] h = '0;
    int j = 0;
    for (int p = 1; p <= W + R; p++) begin
      if ((p & (p - 1)) != 0) begin
        for (int i = 0; i < R; i++)
          if (p[i]) h[i] = h[i] ^ d[j];
        j++;
      end
    end
    return h;
  endfunction

  function automatic logic [W+C-1:0] enc(input logic [W-1:0] d);
    logic [R-1:0] h = ham(d);
    return {(^d) ^ (^h), h, d};
  endfunction

  function automatic logic [W-1:0] fix(input logic [W-1:0] d, input logic [R-1:0] s);
    logic [W-1:0] o = d;
    int j = 0;
    for (int p = 1; p <= W + R; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (p[R-1:0] == s) o[j] = ~o[j];
        j++;
      end
    end
    return o;
  endfunction

  function automatic logic [W-1:0] merge(input logic [W-1:0] base, input logic [W-1:0] nw,
                                         input logic [NB-1:0] st);
    logic [W-1:0] o = base;
    for (int b = 0; b < NB; b++)
      if (st[b]) o[8*b +: 8] = nw[8*b +: 8];
    return o;
  endfunction

  st_t             st, nxt;
  logic            buf_valid;
  logic [AW-1:0]   buf_tag;
  logic [W-1:0]    buf_data;

  wire [AW-1:0] word    = bus_addr[AW+OB-1:OB];
  wire          full    = (&bus_strb) && (bus_addr[OB-1:0] == '0);
  wire          hit     = buf_valid && (buf_tag == word);
  wire [R-1:0]  syn     = mem_rdata[W+R-1:W] ^ ham(mem_rdata[W-1:0]);
  wire          par     = ^mem_rdata;
  wire [W-1:0]  corr    = par ? fix(mem_rdata[W-1:0], syn) : mem_rdata[W-1:0];
  wire          dbl     = !par && (syn != '0);
  wire          evict   = (st == IDLE) && bus_we && !full && !hit && buf_valid;

  assign mem_wdata = enc(evict ? buf_data : bus_wdata);
  assign mem_addr  = evict ? buf_tag : word;

  always_comb begin
    mem_we    = 1'b0;
    mem_re    = 1'b0;
    bus_ready = 1'b0;
    bus_rdata = corr;
    bus_rerr  = 1'b0;
    nxt       = st;
    case (st)
      IDLE: begin
        if (bus_we && full) begin
          mem_we    = 1'b1;
          bus_ready = 1'b1;
        end else if (bus_we) begin
          if (hit)            bus_ready = 1'b1;
          else if (buf_valid) begin mem_we = 1'b1; nxt = FETCH; end
          else                begin mem_re = 1'b1; nxt = MERGE; end
        end else if (bus_re) begin
          if (hit) begin
            bus_ready = 1'b1;
            bus_rdata = buf_data;
          end else begin
            mem_re = 1'b1;
            nxt    = RDATA;
          end
        end else begin
          bus_ready = 1'b1;
        end
      end
      FETCH: begin
        mem_re = 1'b1;
        nxt    = MERGE;
      end
      default: begin
        bus_ready = 1'b1;
        bus_rerr  = dbl;
        nxt       = IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= IDLE;
      buf_valid <= 1'b0;
      buf_tag   <= '0;
      buf_data  <= '0;
    end else begin
      st <= nxt;
      if (st == IDLE && bus_we && hit) begin
        if (full) buf_valid <= 1'b0;
        else      buf_data  <= merge(buf_data, bus_wdata, bus_strb);
      end else if (st == MERGE) begin
        buf_data  <= merge(corr, bus_wdata, bus_strb);
        buf_tag   <= word;
        buf_valid <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/ecc_merge_buf_chk.sv
module ecc_merge_buf_chk #(
  parameter int W  = 32,
  parameter int AW = 8
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [AW+$clog2(W/8)-1:0] bus_addr,
  input logic [W/8-1:0]            bus_strb,
  input logic                      bus_we,
  input logic                      bus_re,
  input logic                      bus_ready,
  input logic [W-1:0]              bus_rdata,
  input logic [AW-1:0]             mem_addr,
  input logic                      mem_we,
  input logic                      mem_re,
  input logic [W+((W>32)?8:7)-1:0] mem_wdata,
  input logic                      buf_valid,
  input logic [AW-1:0]             buf_tag,
  input logic [W-1:0]              buf_data
);
  localparam int OB = $clog2(W/8);
  wire [AW-1:0] a_word = bus_addr[AW+OB-1:OB];
  wire          a_full = (&bus_strb) && (bus_addr[OB-1:0] == '0);
  wire          a_hit  = buf_valid && (buf_tag == a_word);

  // R1
  full_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we && a_full |-> mem_we && bus_ready && mem_addr == a_word);
  // R2
  no_partial_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we && !a_full && mem_we |-> mem_addr != a_word);
  // R3
  merge_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we && !a_full && a_hit |-> bus_ready && !mem_we && !mem_re);
  // R4
  evict_content_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we && !(bus_we && a_full) |-> buf_valid && mem_addr == buf_tag && mem_wdata[W-1:0] == buf_data);
  // R5
  read_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_re && a_hit |-> bus_ready && bus_rdata == buf_data && !mem_re && !mem_we);
  // R6
  read_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_re && !a_hit && !bus_ready |=> bus_ready);
  // R9
  drop_on_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(buf_valid) |-> $past(bus_we && a_full));
  // R12
  port_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));
endmodule

bind ecc_merge_buf ecc_merge_buf_chk #(.W(W), .AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_strb(bus_strb),
  .bus_we(bus_we), .bus_re(bus_re), .bus_ready(bus_ready), .bus_rdata(bus_rdata),
  .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re), .mem_wdata(mem_wdata),
  .buf_valid(buf_valid), .buf_tag(buf_tag), .buf_data(buf_data));

// File: tb/ecc_merge_buf_test.sv
module ecc_merge_buf_test;
  localparam int W = 32, AW = 8, C = 7;

  logic clk = 0, rst_n = 0;
  logic [AW+1:0] bus_addr = '0;
  logic [W-1:0] bus_wdata = '0, bus_rdata;
  logic [3:0] bus_strb = '0;
  logic bus_we = 0, bus_re = 0, bus_ready, bus_rerr;
  logic [AW-1:0] mem_addr;
  logic mem_we, mem_re;
  logic [W+C-1:0] mem_wdata, mem_rdata;

  logic [W+C-1:0] mem [0:(1<<AW)-1];
  logic [AW-1:0] inj_addr = '0;
  logic [W+C-1:0] inj_mask = '0;
  int wr_cnt = 0, checks = 0, fails = 0;

  always #5 clk = ~clk;

  ecc_merge_buf #(.W(W), .AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_strb(bus_strb), .bus_we(bus_we), .bus_re(bus_re), .bus_ready(bus_ready),
    .bus_rdata(bus_rdata), .bus_rerr(bus_rerr), .mem_addr(mem_addr), .mem_we(mem_we),
    .mem_re(mem_re), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata));

  always @(posedge clk) begin
    if (mem_we) begin
      mem[mem_addr] <= mem_wdata;
      wr_cnt <= wr_cnt + 1;
    end
    if (mem_re) mem_rdata <= mem[mem_addr] ^ ((mem_addr == inj_addr) ? inj_mask : '0);
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [AW+1:0] ba(input int w, input int off);
    return AW'(w) * 4 + (AW+2)'(off);
  endfunction

  logic [W-1:0] rd;
  logic er;
  int cyc, w0;

  task automatic xfer(input logic we, input logic [AW+1:0] a, input logic [W-1:0] d,
                      input logic [3:0] s);
    @(negedge clk);
    bus_we = we; bus_re = !we; bus_addr = a; bus_wdata = d; bus_strb = s;
    cyc = 0;
    forever begin
      #1;
      cyc++;
      if (bus_ready || cyc > 40) break;
      @(negedge clk);
    end
    if (cyc > 40) check("watchdog", 64'(cyc), 64'd0);
    rd = bus_rdata; er = bus_rerr;
    @(posedge clk);
    #1 bus_we = 0; bus_re = 0;
  endtask

  task automatic do_reset;
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
  endtask

  task automatic t_reset_state;
    @(negedge clk); #1;
    check("R10 idle ready", 64'(bus_ready), 64'd1);
    check("R10 idle port", 64'({mem_we, mem_re}), 64'd0);
  endtask

  task automatic t_full_and_read;
    w0 = wr_cnt;
    xfer(1, ba(3,0), 32'h11223344, 4'hF);
    check("R1 cycles", 64'(cyc), 64'd1);
    check("R1 stored", 64'(mem[3][W-1:0]), 64'h11223344);
    check("R1 writes", 64'(wr_cnt - w0), 64'd1);
    xfer(1, ba(5,0), 32'hCAFEF00D, 4'hF);
    xfer(1, ba(7,0), 32'h0, 4'hF);
    xfer(1, ba(9,0), 32'h55555555, 4'hF);
    xfer(0, ba(3,0), '0, '0);
    check("R6 read miss data", 64'(rd), 64'h11223344);
    check("R6 read miss cycles", 64'(cyc), 64'd2);
  endtask

  task automatic t_partial_merge;
    w0 = wr_cnt;
    xfer(1, ba(3,0), 32'h000000AA, 4'b0001);
    check("R6 partial fetch cycles", 64'(cyc), 64'd2);
    check("R2 array untouched", 64'(mem[3][W-1:0]), 64'h11223344);
    check("R2 no write", 64'(wr_cnt - w0), 64'd0);
    xfer(0, ba(3,0), '0, '0);
    check("R5 hit data", 64'(rd), 64'h112233AA);
    check("R5 hit cycles", 64'(cyc), 64'd1);
    xfer(1, ba(3,0), 32'h00BB0000, 4'b0100);
    check("R3 merge cycles", 64'(cyc), 64'd1);
    check("R3 no write", 64'(wr_cnt - w0), 64'd0);
    xfer(0, ba(3,0), '0, '0);
    check("R3 merged data", 64'(rd), 64'h11BB33AA);
  endtask

  task automatic t_evict;
    w0 = wr_cnt;
    xfer(1, ba(5,0), 32'h77000000, 4'b1000);
    check("R4 evict cycles", 64'(cyc), 64'd3);
    check("R4 evicted word", 64'(mem[3][W-1:0]), 64'h11BB33AA);
    check("R4 one write", 64'(wr_cnt - w0), 64'd1);
    xfer(0, ba(5,0), '0, '0);
    check("R4 new merge", 64'(rd), 64'h77FEF00D);
  endtask

  task automatic t_unaligned;
    xfer(1, ba(7,1), 32'h12345678, 4'hF);
    check("R11 unaligned partial cycles", 64'(cyc), 64'd3);
    check("R11 word not stored", 64'(mem[7][W-1:0]), 64'h0);
    check("R11 evicted prior", 64'(mem[5][W-1:0]), 64'h77FEF00D);
    xfer(0, ba(7,0), '0, '0);
    check("R11 buffered", 64'(rd), 64'h12345678);
  endtask

  task automatic t_full_drop_and_flush;
    xfer(1, ba(7,0), 32'h9ABCDEF0, 4'hF);
    check("R9 write through", 64'(mem[7][W-1:0]), 64'h9ABCDEF0);
    w0 = wr_cnt;
    xfer(1, ba(9,0), 32'h0000CC00, 4'b0010);
    check("R9 no evict cycles", 64'(cyc), 64'd2);
    check("R9 no evict write", 64'(wr_cnt - w0), 64'd0);
    xfer(0, ba(9,0), '0, '0);
    check("R9 read pending", 64'(rd), 64'h5555CC55);
    xfer(1, ba(9,0), rd, 4'hF);
    check("R9 flushed", 64'(mem[9][W-1:0]), 64'h5555CC55);
  endtask

  task automatic t_reset_loss;
    xfer(1, ba(10,0), 32'h0, 4'hF);
    xfer(1, ba(10,0), 32'h000000FF, 4'b0001);
    do_reset;
    t_reset_state;
    xfer(0, ba(10,0), '0, '0);
    check("R10 lost after reset", 64'(rd), 64'h0);
    check("R10 read from array cycles", 64'(cyc), 64'd2);
  endtask

  task automatic t_ecc;
    xfer(1, ba(12,0), 32'hA5A55A5A, 4'hF);
    inj_addr = 12; inj_mask = (W+C)'(1) << 5;
    xfer(0, ba(12,0), '0, '0);
    check("R7 data bit fixed", 64'({er, rd}), {31'd0, 1'b0, 32'hA5A55A5A});
    inj_mask = (W+C)'(1) << 33;
    xfer(0, ba(12,0), '0, '0);
    check("R7 check bit fixed", 64'({er, rd}), {31'd0, 1'b0, 32'hA5A55A5A});
    inj_mask = ((W+C)'(1) << 1) | ((W+C)'(1) << 20);
    xfer(0, ba(12,0), '0, '0);
    check("R8 double flag", 64'(er), 64'd1);
    xfer(1, ba(14,0), 32'h0F0F0F0F, 4'hF);
    inj_addr = 14; inj_mask = (W+C)'(1) << 8;
    xfer(1, ba(14,0), 32'h000000EE, 4'b0001);
    check("R7 merge path no flag", 64'(er), 64'd0);
    inj_mask = '0;
    xfer(0, ba(14,0), '0, '0);
    check("R7 merge path fixed", 64'(rd), 64'h0F0F0FEE);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1;
    t_reset_state;
    t_full_and_read;
    t_partial_merge;
    t_evict;
    t_unaligned;
    t_full_drop_and_flush;
    t_reset_loss;
    t_ecc;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule